// File: doc/BRIEF.md
# Byte-to-Word Flash Write Packer

The packer turns a byte-granular write request (a start byte address, a byte count and a stream of bytes) into a series of aligned 32-bit word-program commands. Each target word is read from the array first. Lanes that the request does not cover keep their current contents, so a write may begin or end in the middle of a word. Before the packer issues a word, it checks that programming it would only clear bits that are currently set, which means the word is sufficiently erased. It stops at the first problem.

A write starts with a one-cycle `start` pulse. The packer then takes bytes with a valid/ready handshake, reads each word through a read port that returns data one cycle after the request, and hands each finished word to a program port. That port holds its request until the acknowledge arrives, and the acknowledge carries an error code. At the end the packer raises `done` for one cycle, together with a status, the error code from the program port and the number of bytes taken from the stream. The program/erase sequencing and any cache maintenance are left to the neighbouring logic.

The controller has seven states:
- IDLE goes to FINISH on a start with zero count, and to RD_REQ on any other start.
- RD_REQ always goes to RD_WAIT.
- RD_WAIT always goes to GATHER.
- GATHER stays put until it has accepted the last byte of the word or the last byte of the request, then goes to CHECK.
- CHECK goes to WRITE when the erase test holds, and to FINISH otherwise.
- WRITE waits for the acknowledge. On an error it goes to FINISH. With bytes left it goes to RD_REQ, and with none left it goes to FINISH.
- FINISH always goes to IDLE.

Top module: `flash_word_packer`

## Requirements
- R1: The first word address is the start address with bits 1:0 cleared. Each following word address is 4 higher, and every address issued on the read and program ports has bits 1:0 at zero.
- R2: Bytes are packed little-endian: the k-th byte that lands in a word occupies lane j, bits 8j+7..8j, with lanes filled in rising order.
- R3: In the first word, the lanes below start address bits 1:0 carry the current contents of that word as read from the array.
- R4: If the count runs out inside the first word, the lanes above the last written byte also carry the current contents.
- R5: In a trailing partial word, the low lanes hold input bytes and the upper lanes hold the current contents.
- R6: When (current AND new) differs from the new word, the transfer ends with status 1 (not erased) and that word is not issued. `bytes_used` still includes the bytes taken for that word.
- R7: When an acknowledge carries a nonzero error, the transfer ends with status 2. That code appears on `err_code`, and no further read, program request or byte acceptance follows.
- R8: A start with zero count gives `done` on the next cycle with status 0 and `bytes_used` 0, and issues no read, no program request and no `in_ready`.
- R9: Each word is read exactly once, by a single-cycle `rd_req`, and `rd_data` is sampled on the cycle after it.
- R10: A program request stays asserted with stable address and data until `wr_ack`.
- R11: `done` is a single-cycle pulse. On success the status is 0, `err_code` is 0 and `bytes_used` equals the byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (sampled in IDLE) |
| start_addr | input | AW | First byte address |
| byte_cnt | input | CW | Number of bytes to write |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Packer accepts a byte |
| rd_req | output | 1 | Array read request |
| rd_addr | output | AW | Word-aligned read address |
| rd_data | input | 32 | Array word, valid one cycle after rd_req |
| wr_req | output | 1 | Word program request |
| wr_addr | output | AW | Word-aligned program address |
| wr_data | output | 32 | Word to program |
| wr_ack | input | 1 | Program request completed |
| wr_err | input | EW | Error code with wr_ack, 0 = success |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 not erased, 2 program error |
| err_code | output | EW | Error code returned by the program port |
| bytes_used | output | CW | Bytes taken from the stream |

## Verification
The hardest situations to reach from the ports are an erase failure or a program error that lands on a later word of a transfer, rather than on the first word. The bench reaches them by controlling the array contents: most words are fully erased, and a few hold random partial patterns, so that failures fall at varied word positions. The program responder injects an error on a chosen write index with random acknowledge delays. Directed cases pin down the head-only, head-plus-tail and zero-count shapes.

// File: rtl/flash_packer_pkg.sv
package flash_packer_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_GATHER,
        ST_CHECK,
        ST_WRITE,
        ST_FINISH
    } pk_state_e;

    localparam logic [1:0] PK_OK          = 2'd0;
    localparam logic [1:0] PK_NOT_ERASED  = 2'd1;
    localparam logic [1:0] PK_WR_FAIL     = 2'd2;
endpackage

// File: rtl/packer_lane_insert.sv
module packer_lane_insert #(
    parameter int LANES = 4,
    localparam int WW = LANES * 8,
    localparam int LW = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [WW-1:0] word_in,
    input  logic [LW-1:0] lane,
    input  logic [7:0]    byte_in,
    output logic [WW-1:0] word_out
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign word_out[8*g +: 8] = (lane == LW'(g)) ? byte_in : word_in[8*g +: 8];
    end
endmodule

// File: rtl/packer_erase_check.sv
module packer_erase_check #(
    parameter int LANES = 4,
    localparam int WW = LANES * 8
) (
    input  logic [WW-1:0] cur_word,
    input  logic [WW-1:0] new_word,
    output logic          erased_ok
);
    logic [LANES-1:0] lane_ok;
    for (genvar g = 0; g < LANES; g++) begin : g_chk
        assign lane_ok[g] = ((cur_word[8*g +: 8] & new_word[8*g +: 8]) == new_word[8*g +: 8]);
    end
    assign erased_ok = &lane_ok;
endmodule

// File: rtl/flash_word_packer.sv
module flash_word_packer
    import flash_packer_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int EW = 4,
    localparam int LANES = 4,
    localparam int WW = LANES * 8,
    localparam int LW = $clog2(LANES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic [CW-1:0] byte_cnt,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    output logic          in_ready,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic [WW-1:0] rd_data,
    output logic          wr_req,
    output logic [AW-1:0] wr_addr,
    output logic [WW-1:0] wr_data,
    input  logic          wr_ack,
    input  logic [EW-1:0] wr_err,
    output logic          busy,
    output logic          done,
    output logic [1:0]    status,
    output logic [EW-1:0] err_code,
    output logic [CW-1:0] bytes_used
);
    pk_state_e     state_q, state_d;
    logic [AW-1:0] waddr_q;
    logic [LW-1:0] lane_q;
    logic [CW-1:0] remain_q;
    logic [CW-1:0] used_q;
    logic [WW-1:0] old_q;
    logic [WW-1:0] word_q;
    logic [1:0]    status_q;
    logic [EW-1:0] err_q;

    logic [WW-1:0] word_ins;
    logic          erased_ok;
    logic          take_byte;
    logic          word_last;
    logic          wr_bad;

    packer_lane_insert #(.LANES(LANES)) u_ins (
        .word_in  (word_q),
        .lane     (lane_q),
        .byte_in  (in_data),
        .word_out (word_ins)
    );

    packer_erase_check #(.LANES(LANES)) u_chk (
        .cur_word  (old_q),
        .new_word  (word_q),
        .erased_ok (erased_ok)
    );

    assign take_byte = (state_q == ST_GATHER) && in_valid;
    assign word_last = (remain_q == CW'(1)) || (lane_q == LW'(LANES - 1));
    assign wr_bad    = (wr_err != '0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = (byte_cnt == '0) ? ST_FINISH : ST_RD_REQ;
            end
            ST_RD_REQ:  state_d = ST_RD_WAIT;
            ST_RD_WAIT: state_d = ST_GATHER;
            ST_GATHER: begin
                if (take_byte && word_last) state_d = ST_CHECK;
            end
            ST_CHECK:   state_d = erased_ok ? ST_WRITE : ST_FINISH;
            ST_WRITE: begin
                if (wr_ack) begin
                    if (wr_bad || remain_q == '0) state_d = ST_FINISH;
                    else                          state_d = ST_RD_REQ;
                end
            end
            ST_FINISH:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            waddr_q  <= '0;
            lane_q   <= '0;
            remain_q <= '0;
            used_q   <= '0;
            old_q    <= '0;
            word_q   <= '0;
            status_q <= PK_OK;
            err_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        waddr_q  <= {start_addr[AW-1:2], 2'b00};
                        lane_q   <= start_addr[1:0];
                        remain_q <= byte_cnt;
                        used_q   <= '0;
                        status_q <= PK_OK;
                        err_q    <= '0;
                    end
                end
                ST_RD_WAIT: begin
                    old_q  <= rd_data;
                    word_q <= rd_data;
                end
                ST_GATHER: begin
                    if (take_byte) begin
                        word_q   <= word_ins;
                        lane_q   <= lane_q + LW'(1);
                        remain_q <= remain_q - CW'(1);
                        used_q   <= used_q + CW'(1);
                    end
                end
                ST_CHECK: begin
                    if (!erased_ok) status_q <= PK_NOT_ERASED;
                end
                ST_WRITE: begin
                    if (wr_ack) begin
                        if (wr_bad) begin
                            status_q <= PK_WR_FAIL;
                            err_q    <= wr_err;
                        end else begin
                            waddr_q <= waddr_q + AW'(LANES);
                            lane_q  <= '0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        in_ready   = (state_q == ST_GATHER);
        rd_req     = (state_q == ST_RD_REQ);
        rd_addr    = waddr_q;
        wr_req     = (state_q == ST_WRITE);
        wr_addr    = waddr_q;
        wr_data    = word_q;
        busy       = (state_q != ST_IDLE);
        done       = (state_q == ST_FINISH);
        status     = status_q;
        err_code   = err_q;
        bytes_used = used_q;
    end

    AST_WR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req || rd_req) |-> (wr_addr[1:0] == 2'b00 && rd_addr[1:0] == 2'b00)); // R1
    AST_WR_ERASED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> ((old_q & wr_data) == wr_data)); // R6
    AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req); // R9
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data))); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_FAIL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_ack && wr_err != '0) |=> (done && !rd_req && !in_ready)); // R7
endmodule

// File: tb/sim_flash_word_packer.sv
module sim_flash_word_packer;
    localparam int AW = 32;
    localparam int CW = 16;
    localparam int EW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [CW-1:0] byte_cnt = '0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_data = '0;
    logic          in_ready;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic [31:0]   rd_data = '0;
    logic          wr_req;
    logic [AW-1:0] wr_addr;
    logic [31:0]   wr_data;
    logic          wr_ack = 1'b0;
    logic [EW-1:0] wr_err = '0;
    logic          busy, done;
    logic [1:0]    status;
    logic [EW-1:0] err_code;
    logic [CW-1:0] bytes_used;

    always #4 clk = ~clk;

    flash_word_packer #(.AW(AW), .CW(CW), .EW(EW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .byte_cnt(byte_cnt), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
        .wr_err(wr_err), .busy(busy), .done(done), .status(status),
        .err_code(err_code), .bytes_used(bytes_used)
    );

    int checks = 0;
    int fails = 0;

    logic [31:0] mem [64];
    logic [7:0]  src [64];
    int          src_base = 0;
    int          cur_cnt = 0;
    int          acc_idx = 0;
    int          rd_cnt = 0;
    int          rdy_cnt = 0;
    int          wcount = 0;
    int          err_abs = -1;
    logic [EW-1:0] err_val = '0;
    logic [31:0] log_addr [1024];
    logic [31:0] log_data [1024];
    int          dly = 0;

    logic [31:0] exp_addr [16];
    logic [31:0] exp_data [16];
    int          exp_n, exp_bytes;
    logic [1:0]  exp_status;
    logic [EW-1:0] exp_err;

    // Array read responder: data one cycle after request
    always @(posedge clk) begin
        if (rd_req) begin
            rd_data <= mem[rd_addr[7:2]];
            rd_cnt  <= rd_cnt + 1;
        end
        if (in_ready) rdy_cnt <= rdy_cnt + 1;
        if (in_valid && in_ready) acc_idx <= acc_idx + 1;
    end

    // Program responder with random delay and injected error
    always @(posedge clk) begin
        if (wr_req && !wr_ack) begin
            if (dly == 0) begin
                wr_ack <= 1'b1;
                log_addr[wcount % 1024] = wr_addr;
                log_data[wcount % 1024] = wr_data;
                if (wcount == err_abs) wr_err <= err_val;
                else begin
                    wr_err <= '0;
                    mem[wr_addr[7:2]] = wr_data;
                end
                wcount <= wcount + 1;
                dly <= $urandom % 3;
            end else begin
                dly <= dly - 1;
            end
        end else begin
            wr_ack <= 1'b0;
            wr_err <= '0;
        end
    end

    // Byte source
    always @(negedge clk) begin
        if ((acc_idx - src_base) < cur_cnt) begin
            in_valid <= ($urandom % 4) != 0;
            in_data  <= src[(acc_idx - src_base) % 64];
        end else begin
            in_valid <= 1'b0;
            in_data  <= 8'h00;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // Reference model (R1-style addressing, lane merge, erase test, error stop)
    task automatic model(input logic [31:0] sa, input int cnt, input int err_at);
        int rem, k, lo;
        logic [31:0] a, oldw, nw;
        exp_n = 0; exp_bytes = 0; exp_status = 2'd0; exp_err = '0;
        rem = cnt; k = 0; lo = int'(sa[1:0]); a = {sa[31:2], 2'b00};
        while (rem > 0) begin
            oldw = mem[a[7:2]];
            nw = oldw;
            for (int l = lo; l < 4 && rem > 0; l++) begin
                nw[8*l +: 8] = src[k];
                k++; rem--;
            end
            exp_bytes = k;
            if ((oldw & nw) != nw) begin
                exp_status = 2'd1;
                return;
            end
            exp_addr[exp_n] = a;
            exp_data[exp_n] = nw;
            if (exp_n == err_at) begin
                exp_status = 2'd2;
                exp_err = err_val;
                exp_n++;
                return;
            end
            exp_n++;
            a = a + 4;
            lo = 0;
        end
    endtask

    bit hung = 0;

    task automatic run(input logic [31:0] sa, input int cnt, input int err_at, input string tag);
        int wbase, rd0, rdy0, waited;
        model(sa, cnt, err_at);
        wbase = wcount;
        rd0 = rd_cnt; rdy0 = rdy_cnt;
        err_abs = (err_at >= 0) ? wbase + err_at : -1;
        @(negedge clk);
        src_base = acc_idx;
        cur_cnt = cnt;
        start_addr = sa;
        byte_cnt = CW'(cnt);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        waited = 0;
        while (!done && waited < 3000) begin
            @(negedge clk);
            waited++;
        end
        if (!done) begin
            hung = 1;
            chk(0, "R11", {tag, " watchdog"}, 32'(waited), 32'd0);
            return;
        end
        chk(status == exp_status, exp_status == 2'd1 ? "R6" : (exp_status == 2'd2 ? "R7" : "R11"),
            {tag, " status"}, 32'(status), 32'(exp_status));
        chk(int'(bytes_used) == exp_bytes, "R11", {tag, " bytes_used"}, 32'(bytes_used), 32'(exp_bytes));
        chk(err_code == exp_err, "R7", {tag, " err_code"}, 32'(err_code), 32'(exp_err));
        chk(wcount - wbase == exp_n, "R6", {tag, " write count"}, 32'(wcount - wbase), 32'(exp_n));
        chk(rd_cnt - rd0 == exp_n + (exp_status == 2'd1 ? 1 : 0), "R9", {tag, " read count"},
            32'(rd_cnt - rd0), 32'(exp_n + (exp_status == 2'd1 ? 1 : 0)));
        if (cnt == 0)
            chk(rdy_cnt == rdy0 && waited == 0, "R8", {tag, " zero count quiet"}, 32'(rdy_cnt - rdy0), 32'd0);
        for (int i = 0; i < exp_n && i < (wcount - wbase); i++) begin
            chk(log_addr[(wbase + i) % 1024] == exp_addr[i], "R1", {tag, " word addr"},
                log_addr[(wbase + i) % 1024], exp_addr[i]);
            chk(log_data[(wbase + i) % 1024] == exp_data[i], "R2", {tag, " word data (R3 R4 R5)"},
                log_data[(wbase + i) % 1024], exp_data[i]);
        end
        @(negedge clk);
        chk(!done, "R11", {tag, " done pulse width"}, 32'(done), 32'd0);
    endtask

    task automatic fill_mem(input int dirty_pct);
        for (int i = 0; i < 64; i++)
            mem[i] = (($urandom % 100) < dirty_pct) ? ($urandom | $urandom) : 32'hFFFF_FFFF;
        for (int i = 0; i < 64; i++) src[i] = 8'($urandom);
    endtask

    initial begin
        void'($urandom(32'h0000_5EED));
        fill_mem(0);
        repeat (3) @(negedge clk);
        chk(!done && !rd_req && !wr_req && !in_ready && !busy, "R11", "reset outputs quiet",
            {27'd0, done, rd_req, wr_req, in_ready, busy}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: aligned two words
        fill_mem(0); run(32'h10, 8, -1, "aligned");
        // R3 R4: head only, count ends inside first word
        fill_mem(0); mem[8] = 32'hA5C3_7E11; run(32'h21, 2, -1, "head-only");
        // R3 R5: head and tail partial words
        fill_mem(0); mem[12] = 32'hFF7F_FFFE; mem[14] = 32'hF0FF_FFFF;
        for (int i = 0; i < 6; i++) src[i] = 8'h00 + 8'(i);
        run(32'h33, 6, -1, "head-tail");
        // R5: tail after aligned body
        fill_mem(0); run(32'h40, 13, -1, "tail");
        // R8: zero count
        fill_mem(0); run(32'h50, 0, -1, "zero");
        // R6: erase failure on second word
        fill_mem(0); mem[(32'h80 >> 2) + 1] = 32'h0000_0000;
        for (int i = 0; i < 12; i++) src[i] = 8'hFF;
        run(32'h80, 12, -1, "erase-fail");
        // R7: program error on first write
        fill_mem(0); err_val = 4'h9; run(32'h62, 9, 0, "wr-error");
        // R7: program error on a later write
        fill_mem(0); err_val = 4'h3; run(32'h90, 16, 2, "wr-error-late");

        for (int t = 0; t < 60 && !hung; t++) begin
            int cnt, ea;
            logic [31:0] sa;
            fill_mem(15);
            sa = 32'($urandom % 200);
            cnt = int'($urandom % 50);
            ea = (($urandom % 4) == 0) ? int'($urandom % 4) : -1;
            err_val = 4'($urandom % 15 + 1);
            run(sa, cnt, ea, "random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule